// File: doc/BRIEF.md
# Wait-Stated Bus Memory Slave

This block is an AHB-Lite slave that fronts a word-organised storage array. It captures the address-phase control of each transfer, stretches the data phase by a configurable number of wait cycles using a down-counter that drives `hreadyout`, and returns read data through a mux that is aligned to the data phase. When the registered-read option is set, the read word passes through an output flop, and the slave adds one more wait cycle to reads so that `hreadyout` rises in the same cycle the registered word is valid.

Writes update the array only in the cycle that completes the data phase. Byte and halfword writes touch only the addressed lanes. An address whose word index lies outside the array gets the two-cycle error response and leaves the array unchanged. A new address phase is accepted in the same cycle that the previous data phase completes, so back-to-back transfers run without gaps.

Top module: `ahbl_waitmem`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `hreadyout` is 1 and `hresp` is 0 (OKAY).
- R2: Address, direction and size are sampled only in a cycle where `hready` is 1. Values on `haddr`, `hwrite`, `hsize`, `hsel` and `htrans` during wait cycles of a data phase do not change the transfer in progress.
- R3: A write to an in-range word has a data phase of WAITS+1 cycles: `hreadyout` is low for exactly WAITS cycles, then high, with `hresp` 0 throughout.
- R4: A read of an in-range word has a data phase of WAITS+REG_READ+1 cycles. In the cycle where `hreadyout` is high, `hrdata` holds the stored word at the captured address.
- R5: The array takes `hwdata` only in the completing data-phase cycle (where `hreadyout` is 1). Values driven on `hwdata` during wait cycles are not stored.
- R6: `hsize` 0 writes one byte, 1 a halfword and 2 a full 32-bit word. Byte lane k holds `hwdata[8k+7:8k]` and is selected by the low address bits (little-endian). Lanes outside the access keep their old contents.
- R7: A transfer whose word index (`haddr` without its byte-offset bits) is at or above DEPTH gets `hresp`=1 with `hreadyout`=0 in the first data-phase cycle, then `hresp`=1 with `hreadyout`=1 in the second. No word of the array changes.
- R8: When `hready` is 1 and the cycle carries no valid transfer (`hsel`=0, or `htrans` IDLE=00 or BUSY=01; NONSEQ=10 and SEQ=11 are valid), the next cycle shows `hreadyout`=1 and `hresp`=0, and no word changes.
- R9: An address phase driven in the completing cycle of a previous transfer is accepted. Its data phase follows at once with the lengths of R3/R4, and a read that follows a write to the same word returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address |
| htrans | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Access size (0 byte, 1 halfword, 2 word) |
| hwdata | input | DW | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready: previous transfer complete |
| hreadyout | output | 1 | Slave ready, low during inserted wait cycles |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | DW | Read data, valid when hreadyout is high |

## Verification
The address phase is taken at a rising edge. The data phase then starts, and the edge that closes it is due WAITS+1 cycles later for a write, WAITS+REG_READ+1 cycles later for a read, and two cycles later for an out-of-range access. The bench drives every input at the falling edge and reads `hreadyout`, `hresp` and `hrdata` half a cycle before each rising edge. It counts the data-phase cycles until `hreadyout` is first seen high, compares that count to the figure above, and takes read data and the final response in that same half-cycle. During every wait cycle it scrambles the control and write-data inputs, so a slave that stores or captures early produces a wrong word on a later readback. Idle and deselected cycles are checked one cycle after they are driven.

// File: rtl/waitmem_pkg.sv
package waitmem_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;
endpackage

// File: rtl/wm_rst_sync.sv
module wm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wm_capture.sv
module wm_capture
  import waitmem_pkg::*;
#(
  parameter int AW    = 10,
  parameter int OFFW  = 2,
  parameter int IDXW  = AW - OFFW,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [AW-1:0] haddr,
  input  logic [2:0]    hsize,
  output logic          start,
  output logic          bad_now,
  output logic          write_q,
  output logic [AW-1:0] addr_q,
  output logic [2:0]    size_q
);
  localparam logic [IDXW:0] DEPTH_W = (IDXW+1)'(DEPTH);

  trans_e          tr;
  logic [IDXW-1:0] idx_now;
  logic            write_d;
  logic [AW-1:0]   addr_d;
  logic [2:0]      size_d;

  assign tr      = trans_e'(htrans);
  assign start   = hready & hsel & ((tr == TR_NONSEQ) || (tr == TR_SEQ));
  assign idx_now = haddr[AW-1:OFFW];
  assign bad_now = ({1'b0, idx_now} >= DEPTH_W);

  // Capture enable is the bus-wide ready.
  always_comb begin
    write_d = write_q;
    addr_d  = addr_q;
    size_d  = size_q;
    if (hready) begin
      write_d = hwrite;
      addr_d  = haddr;
      size_d  = hsize;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
    end else begin
      write_q <= write_d;
      addr_q  <= addr_d;
      size_q  <= size_d;
    end
  end

  // R2: captured control holds while the bus is stalled
  assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable({write_q, addr_q, size_q}));
endmodule

// File: rtl/wm_pace.sv
module wm_pace #(
  parameter int WAITS    = 2,
  parameter int REG_READ = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hready,
  input  logic start,
  input  logic hwrite,
  input  logic bad_now,
  output logic act_q,
  output logic err_q,
  output logic done,
  output logic load_rd,
  output logic hreadyout,
  output logic hresp
);
  localparam int MAXW   = WAITS + REG_READ;
  localparam int CW     = $clog2(MAXW + 2);
  localparam int MAXLOW = (MAXW > 0) ? MAXW : 1;
  localparam logic [CW-1:0] WR_LOAD = CW'(WAITS);
  localparam logic [CW-1:0] RD_LOAD = CW'(MAXW);
  localparam logic [CW-1:0] ER_LOAD = CW'(1);

  logic          act_d, err_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    err_d = err_q;
    cnt_d = cnt_q;
    if (act_q && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
    if (hready) begin
      act_d = start;
      err_d = start & bad_now;
      if (!start)       cnt_d = '0;
      else if (bad_now) cnt_d = ER_LOAD;
      else if (hwrite)  cnt_d = WR_LOAD;
      else              cnt_d = RD_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end

  assign done      = act_q & (cnt_q == '0);
  assign load_rd   = act_q & (cnt_q != '0) & ~err_q;
  assign hreadyout = ~act_q | (cnt_q == '0);
  assign hresp     = act_q & err_q;

  // Checker: length of the current run of low-ready cycles
  logic [CW:0] low_run_q, low_run_d;
  assign low_run_d = hreadyout ? '0 : low_run_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run_q <= '0;
    else        low_run_q <= low_run_d;
  end

  // R3/R4: no data phase stalls longer than the configured waits
  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= (CW+1)'(MAXLOW));
  // R7: first error cycle is followed by the completing error cycle
  assert_err_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));
  // R7: a completing error is always preceded by the stalled error cycle
  assert_err_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && hreadyout) |-> $past(hresp && !hreadyout));
endmodule

// File: rtl/wm_store.sv
module wm_store #(
  parameter int DW       = 32,
  parameter int DEPTH    = 256,
  parameter int IDXW     = 8,
  parameter int OFFW     = 2,
  parameter int REG_READ = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [OFFW-1:0] off,
  input  logic [2:0]      size,
  input  logic [DW-1:0]   wdata,
  input  logic            ld,
  output logic [DW-1:0]   rdata
);
  localparam int LANES = DW / 8;
  localparam int MW    = $clog2(DEPTH);
  localparam logic [IDXW:0] DEPTH_W = (IDXW+1)'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [LANES-1:0] be;
  logic [MW-1:0]    midx;
  logic             in_range;
  logic [DW-1:0]    word_c;

  // Lane l belongs to the access when it shares the aligned block with off.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be[l] = ((OFFW'(l) >> size) == (off >> size));
  end

  assign midx     = idx[MW-1:0];
  assign in_range = ({1'b0, idx} < DEPTH_W);

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && be[l]) mem[midx][l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end

  assign word_c = in_range ? mem[midx] : '0;

  if (REG_READ != 0) begin : g_regrd
    logic [DW-1:0] rd_q, rd_d;
    assign rd_d = ld ? word_c : rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
    end
    assign rdata = rd_q;
  end else begin : g_combrd
    assign rdata = word_c;
  end

  // R7: the array is never written at an out-of-range index
  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> in_range);
endmodule

// File: rtl/ahbl_waitmem.sv
module ahbl_waitmem
  import waitmem_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 10,
  parameter int DEPTH    = 256,
  parameter int WAITS    = 2,
  parameter int REG_READ = 1
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic [DW-1:0] hwdata,
  input  logic          hready,
  output logic          hreadyout,
  output logic          hresp,
  output logic [DW-1:0] hrdata
);
  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);
  localparam int IDXW  = AW - OFFW;

  logic          rst_n;
  logic          start, bad_now;
  logic          write_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    size_q;
  logic          act_q, err_q, done, load_rd;
  logic          wr_en, rd_valid;
  logic [DW-1:0] rd_word;

  wm_rst_sync #(.STAGES(2)) u_rst (
    .clk(hclk), .arst_n(hresetn), .rst_n(rst_n)
  );

  wm_capture #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW), .DEPTH(DEPTH)) u_cap (
    .clk(hclk), .rst_n(rst_n), .hready(hready), .hsel(hsel), .htrans(htrans),
    .hwrite(hwrite), .haddr(haddr), .hsize(hsize), .start(start),
    .bad_now(bad_now), .write_q(write_q), .addr_q(addr_q), .size_q(size_q)
  );

  wm_pace #(.WAITS(WAITS), .REG_READ(REG_READ)) u_pace (
    .clk(hclk), .rst_n(rst_n), .hready(hready), .start(start), .hwrite(hwrite),
    .bad_now(bad_now), .act_q(act_q), .err_q(err_q), .done(done),
    .load_rd(load_rd), .hreadyout(hreadyout), .hresp(hresp)
  );

  assign wr_en    = done & write_q & ~err_q;
  assign rd_valid = act_q & ~write_q & ~err_q;

  wm_store #(.DW(DW), .DEPTH(DEPTH), .IDXW(IDXW), .OFFW(OFFW),
             .REG_READ(REG_READ)) u_store (
    .clk(hclk), .rst_n(rst_n), .we(wr_en), .idx(addr_q[AW-1:OFFW]),
    .off(addr_q[OFFW-1:0]), .size(size_q), .wdata(hwdata),
    .ld(load_rd & ~write_q), .rdata(rd_word)
  );

  assign hrdata = rd_valid ? rd_word : '0;

  // R5: array commit only in a cycle where the slave signals ready
  assert_commit_ready_R5: assert property (@(hclk) disable iff (!rst_n)
    wr_en |-> hreadyout);
  // R8: a cycle with no valid transfer leaves the slave ready and OKAY
  assert_idle_ready_R8: assert property (@(posedge hclk) disable iff (!rst_n)
    (hready && !start) |=> (hreadyout && (hresp == RESP_OKAY)));
endmodule

// File: tb/ahbl_waitmem_tb.sv
module ahbl_waitmem_tb;
  localparam int DW = 32, AW = 6, DEPTH = 12, WAITS = 2, REG_READ = 1;
  localparam int WR_CYC = WAITS + 1;
  localparam int RD_CYC = WAITS + REG_READ + 1;

  logic          hclk = 1'b0;
  logic          hresetn;
  logic          hsel, hwrite;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hsize;
  logic [DW-1:0] hwdata;
  logic          hready, hreadyout, hresp;
  logic [DW-1:0] hrdata;

  always #2 hclk = ~hclk;
  assign hready = hreadyout;

  ahbl_waitmem #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .WAITS(WAITS),
                 .REG_READ(REG_READ)) u_dut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] rd;
  int            cyc;
  logic          ef, el;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic w, input logic [AW-1:0] a, input logic [2:0] s);
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'b10; hwrite = w; haddr = a; hsize = s;
    @(posedge hclk);
  endtask

  // Runs one data phase; optionally drives the next address phase in its last cycle.
  task automatic finish(input logic [DW-1:0] wd, input bit chain, input logic cw,
                        input logic [AW-1:0] ca, input logic [2:0] cs,
                        output logic [DW-1:0] r, output int n,
                        output logic e1, output logic e2);
    bit fin = 0;
    n = 0; e1 = 0; e2 = 0; r = '0;
    while (!fin && n < 20) begin
      @(negedge hclk);
      n++;
      if (n == 1) e1 = hresp;
      if (hreadyout) begin
        hwdata = wd; r = hrdata; e2 = hresp;
        if (chain) begin
          hsel = 1'b1; htrans = 2'b10; hwrite = cw; haddr = ca; hsize = cs;
        end else begin
          hsel = 1'b0; htrans = 2'b00;
        end
        fin = 1;
      end else begin
        hwdata = ~wd; hsel = 1'b1; htrans = 2'b10;
        hwrite = ~hwrite; haddr = haddr ^ 6'h15; hsize = 3'd0;
      end
      @(posedge hclk);
    end
  endtask

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [2:0] s,
                      input logic [DW-1:0] wd);
    start(w, a, s);
    finish(wd, 0, 1'b0, '0, 3'd0, rd, cyc, ef, el);
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b0, AW'(i*4), 3'd2, '0);
      chk(rd === model[i], req, rd, model[i]);
    end
  endtask

  initial begin
    hresetn = 1'b0; hsel = 0; htrans = 0; hwrite = 0; haddr = 0; hsize = 0; hwdata = 0;
    repeat (4) @(posedge hclk);
    @(negedge hclk);
    chk(hreadyout === 1'b1 && hresp === 1'b0, "R1 in reset", {hreadyout, hresp}, 32'h2);
    hresetn = 1'b1;
    repeat (3) @(posedge hclk);
    @(negedge hclk);
    chk(hreadyout === 1'b1 && hresp === 1'b0, "R1 after release", {hreadyout, hresp}, 32'h2);

    // R3 R5 R2: full-word writes with scrambled inputs during waits
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 32'h1357_9BDF ^ (i * 32'h0105_0311);
      xfer(1'b1, AW'(i*4), 3'd2, model[i]);
      chk(cyc == WR_CYC, "R3 write length", cyc, WR_CYC);
      chk(ef === 1'b0 && el === 1'b0, "R3 write okay", {ef, el}, 0);
    end
    // R4 R2 R5: read back, length and data
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b0, AW'(i*4), 3'd2, '0);
      chk(cyc == RD_CYC, "R4 read length", cyc, RD_CYC);
      chk(rd === model[i], "R4 R5 R2 read data", rd, model[i]);
    end

    // R6: byte writes into word 3, halfword writes into word 5
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b = 8'h30 + 8'(k * 17);
      xfer(1'b1, AW'(12 + k), 3'd0, 32'(b) << (8 * k));
      model[3][8*k +: 8] = b;
      chk(cyc == WR_CYC, "R6 byte write length", cyc, WR_CYC);
      xfer(1'b0, 6'd12, 3'd2, '0);
      chk(rd === model[3], "R6 byte lane", rd, model[3]);
    end
    xfer(1'b1, 6'd22, 3'd1, 32'hBEEF_0000);
    model[5][31:16] = 16'hBEEF;
    xfer(1'b0, 6'd20, 3'd2, '0);
    chk(rd === model[5], "R6 upper halfword", rd, model[5]);
    xfer(1'b1, 6'd20, 3'd1, 32'h0000_1234);
    model[5][15:0] = 16'h1234;
    xfer(1'b0, 6'd20, 3'd2, '0);
    chk(rd === model[5], "R6 lower halfword", rd, model[5]);

    // R7: out-of-range word indices, write and read
    for (int i = DEPTH; i < 16; i++) begin
      for (int w = 0; w < 2; w++) begin
        xfer(w[0], AW'(i*4), 3'd2, 32'hDEAD_0000 + 32'(i));
        chk(cyc == 2, "R7 error length", cyc, 2);
        chk(ef === 1'b1 && el === 1'b1, "R7 error both cycles", {ef, el}, 32'h3);
      end
    end
    verify_all("R7 array untouched");

    // R8: IDLE, BUSY and deselected NONSEQ write
    for (int t = 0; t < 3; t++) begin
      @(negedge hclk);
      hsel = (t != 2); htrans = (t == 0) ? 2'b00 : (t == 1) ? 2'b01 : 2'b10;
      hwrite = 1'b1; haddr = 6'd4; hsize = 3'd2;
      @(posedge hclk);
      @(negedge hclk);
      hwdata = 32'hFFFF_FFFF; hsel = 1'b0; htrans = 2'b00;
      chk(hreadyout === 1'b1 && hresp === 1'b0, "R8 no transfer", {hreadyout, hresp}, 32'h2);
      @(posedge hclk);
    end
    xfer(1'b0, 6'd4, 3'd2, '0);
    chk(rd === model[1], "R8 no write", rd, model[1]);

    // R9: pipelined write/read pairs
    start(1'b1, 6'd8, 3'd2);
    finish(32'hCAFE_0001, 1, 1'b0, 6'd8, 3'd2, rd, cyc, ef, el);
    model[2] = 32'hCAFE_0001;
    chk(cyc == WR_CYC, "R9 chained write length", cyc, WR_CYC);
    finish('0, 1, 1'b1, 6'd4, 3'd2, rd, cyc, ef, el);
    chk(cyc == RD_CYC, "R9 chained read length", cyc, RD_CYC);
    chk(rd === model[2], "R9 read after write", rd, model[2]);
    finish(32'h0BAD_F00D, 1, 1'b0, 6'd4, 3'd2, rd, cyc, ef, el);
    model[1] = 32'h0BAD_F00D;
    chk(cyc == WR_CYC, "R9 second chained write", cyc, WR_CYC);
    finish('0, 0, 1'b0, '0, 3'd0, rd, cyc, ef, el);
    chk(rd === model[1] && cyc == RD_CYC, "R9 second read", rd, model[1]);
    verify_all("R9 final contents");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge hclk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule